// File: doc/BRIEF.md
# Encrypting Row Write Controller

The block accepts one row of plaintext, a row address and a key row of the same width through a valid/ready handshake. It forms the ciphertext by XOR of each plaintext bit with the key bit of its own column, so every column may carry a different key. It then programs that ciphertext into a behavioural array of single-transistor nonvolatile cells. A ciphertext 1 is kept as the high-threshold state and a ciphertext 0 as the low-threshold state.

Programming takes two steps. The first step erases the whole selected row to the high-threshold state with a full negative level on its wordline. The second step applies a full positive level to the same wordline. It holds the columns that must go to low threshold at ground and raises every other line to a partial level, which inhibits the cells on those lines. Drive levels are symbolic two-bit codes. A polarity output tells the sign of a full level. The lengths of both steps are parameters. One request occupies a fixed window, after which a one-cycle done pulse is given. A combinational read port on the array model exposes the stored ciphertext of any row.

Top module: `enc_row_writer`

## Requirements
- R1: After reset, req_ready is 1, done is 0, wr_pos is 0, every wordline, bitline and sourceline code is ground (0), and every stored cell reads 1 (high threshold).
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the cycle after the done pulse, and req_valid seen while req_ready is 0 changes nothing.
- R3: The stored row equals req_pt XOR req_key bit by bit, with a different key allowed in every column, and rd_ct bit c is 1 for a high-threshold cell.
- R4: For RST_CYC cycles after acceptance, the selected wordline carries code 3 (full) with wr_pos 0 (negative), every other wordline code 0, and every bitline and sourceline code 0.
- R5: For the next SET_CYC cycles, the selected wordline carries code 3 with wr_pos 1, every other wordline code 1 (one third), column c carries code 0 on both its bitline and sourceline when its ciphertext bit is 0 and code 2 (two thirds) on both when it is 1.
- R6: done is 1 for exactly one cycle, the cycle right after the last set cycle, and req_ready returns to 1 the cycle after that.
- R7: A cell changes only when its wordline carries code 3 while neither its bitline nor its sourceline carries code 2; rows other than the addressed row keep their contents.
- R8: Writing a row that already holds data replaces it fully, moving cells both from high to low and from low to high threshold.
- R9: Code encoding on every line, two bits per line with line i at bits [2i+1:2i]: 0 ground, 1 one third of the write level, 2 two thirds, 3 full level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_row | input | $clog2(ROWS) | Row to write |
| req_pt | input | COLS | Plaintext row |
| req_key | input | COLS | Key row, one bit per column |
| done | output | 1 | One-cycle pulse at the end of the write window |
| wl_drv | output | 2*ROWS | Wordline drive codes |
| bl_drv | output | 2*COLS | Bitline drive codes |
| sl_drv | output | 2*COLS | Sourceline drive codes |
| wr_pos | output | 1 | Sign of a full level: 1 positive, 0 negative |
| rd_row | input | $clog2(ROWS) | Row selected for readback |
| rd_ct | output | COLS | Stored ciphertext of rd_row |

## Verification
The bench walks rows whose ciphertext is all zeros (every column set), all ones (every column inhibited) and mixed, and checks the line codes in each cycle of both steps. A swapped inhibit level or a missing erase step would leave stale cells or flip cells that must hold. A rewrite of an occupied row with a pattern moving bits both ways catches a design that only sets or only erases. A request held valid throughout a busy window must leave its row untouched, which exposes a controller that accepts or latches while busy. The done and ready timing is checked cycle by cycle, so a window one cycle short or long shows up.

// File: rtl/enc_wr_pkg.sv
// Shared types for the encrypting row write controller.
// Assumes two-bit symbolic drive codes; no voltages are modelled.
package enc_wr_pkg;

    // Symbolic line drive level; the sign of a full level is carried apart.
    typedef enum logic [1:0] {
        DRV_GND   = 2'd0,
        DRV_THIRD = 2'd1,
        DRV_TWO3  = 2'd2,
        DRV_FULL  = 2'd3
    } drv_e;

    // Controller phase.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_SET   = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

endpackage

// File: rtl/enc_wr_seq.sv
// Request sequencer: takes a request, forms the ciphertext and steps
// through erase, set and done phases with programmable lengths.
// Assumes RST_CYC >= 1 and SET_CYC >= 1.
module enc_wr_seq
    import enc_wr_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int COLS    = 8,
    parameter int RST_CYC = 1,
    parameter int SET_CYC = 2,
    localparam int RAW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int MAXC   = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC,
    localparam int CW     = $clog2(MAXC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [RAW-1:0]  req_row,
    input  logic [COLS-1:0] req_pt,
    input  logic [COLS-1:0] req_key,
    output logic            req_ready,
    output phase_e          phase,
    output logic [RAW-1:0]  sel_row,
    output logic [COLS-1:0] ct_row,
    output logic            done
);

    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SET_CYC - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          take;

    assign take      = req_valid && (phase_q == PH_IDLE);
    assign req_ready = (phase_q == PH_IDLE);
    assign done      = (phase_q == PH_DONE);
    assign phase     = phase_q;

    // Phase and cycle counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (take) begin
                        phase_q <= PH_ERASE;
                        cnt_q   <= '0;
                    end
                end
                PH_ERASE: begin
                    if (cnt_q == RST_LAST) begin
                        phase_q <= PH_SET;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SET: begin
                    if (cnt_q == SET_LAST) begin
                        phase_q <= PH_DONE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Latch row address and ciphertext on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_row <= '0;
            ct_row  <= '0;
        end else if (take) begin
            sel_row <= req_row;
            ct_row  <= req_pt ^ req_key;
        end
    end

endmodule

// File: rtl/enc_wr_linedrv.sv
// Line driver decode: turns phase, selected row and ciphertext into
// per-line drive codes and the full-level polarity.
// Assumes the same code on a column's bitline and sourceline.
module enc_wr_linedrv
    import enc_wr_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  phase_e            phase,
    input  logic [RAW-1:0]    sel_row,
    input  logic [COLS-1:0]   ct_row,
    output logic [2*ROWS-1:0] wl_drv,
    output logic [2*COLS-1:0] bl_drv,
    output logic [2*COLS-1:0] sl_drv,
    output logic              wr_pos
);

    logic busy;
    assign busy   = (phase == PH_ERASE) || (phase == PH_SET);
    assign wr_pos = (phase == PH_SET);

    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        // Wordline r: full on the selected row, one third elsewhere when setting.
        always_comb begin
            if (!busy)
                wl_drv[2*r +: 2] = DRV_GND;
            else if (sel_row == RAW'(r))
                wl_drv[2*r +: 2] = DRV_FULL;
            else if (wr_pos)
                wl_drv[2*r +: 2] = DRV_THIRD;
            else
                wl_drv[2*r +: 2] = DRV_GND;
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        // Column c: ground to set, two thirds to inhibit a ciphertext 1.
        always_comb begin
            if (wr_pos && ct_row[c]) begin
                bl_drv[2*c +: 2] = DRV_TWO3;
                sl_drv[2*c +: 2] = DRV_TWO3;
            end else begin
                bl_drv[2*c +: 2] = DRV_GND;
                sl_drv[2*c +: 2] = DRV_GND;
            end
        end
    end

endmodule

// File: rtl/enc_wr_cellarray.sv
// Behavioural cell array: one bit per cell, 1 = high threshold.
// A cell follows a full wordline level only when its column is not
// inhibited. Reset models an erased array (all high threshold).
module enc_wr_cellarray
    import enc_wr_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*ROWS-1:0] wl_drv,
    input  logic [2*COLS-1:0] bl_drv,
    input  logic [2*COLS-1:0] sl_drv,
    input  logic              wr_pos,
    input  logic [RAW-1:0]    rd_row,
    output logic [COLS-1:0]   rd_ct
);

    logic [COLS-1:0] cell_q [ROWS];
    logic [COLS-1:0] open_col;

    // Columns whose lines do not inhibit programming.
    always_comb begin
        for (int c = 0; c < COLS; c++)
            open_col[c] = (bl_drv[2*c +: 2] != DRV_TWO3) &&
                          (sl_drv[2*c +: 2] != DRV_TWO3);
    end

    // Cell state update from applied line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                cell_q[r] <= '1;
        end else begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    if ((wl_drv[2*r +: 2] == DRV_FULL) && open_col[c])
                        cell_q[r][c] <= !wr_pos;
        end
    end

    assign rd_ct = cell_q[rd_row];

endmodule

// File: rtl/enc_row_writer.sv
// Top: encrypting row write controller with its behavioural array.
// Assumes requests are held by the source until accepted.
module enc_row_writer
    import enc_wr_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int COLS    = 8,
    parameter int RST_CYC = 1,
    parameter int SET_CYC = 2,
    localparam int RAW    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RAW-1:0]    req_row,
    input  logic [COLS-1:0]   req_pt,
    input  logic [COLS-1:0]   req_key,
    output logic              done,
    output logic [2*ROWS-1:0] wl_drv,
    output logic [2*COLS-1:0] bl_drv,
    output logic [2*COLS-1:0] sl_drv,
    output logic              wr_pos,
    input  logic [RAW-1:0]    rd_row,
    output logic [COLS-1:0]   rd_ct
);

    phase_e          phase;
    logic [RAW-1:0]  sel_row;
    logic [COLS-1:0] ct_row;

    enc_wr_seq #(.ROWS(ROWS), .COLS(COLS), .RST_CYC(RST_CYC), .SET_CYC(SET_CYC)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_row   (req_row),
        .req_pt    (req_pt),
        .req_key   (req_key),
        .req_ready (req_ready),
        .phase     (phase),
        .sel_row   (sel_row),
        .ct_row    (ct_row),
        .done      (done)
    );

    enc_wr_linedrv #(.ROWS(ROWS), .COLS(COLS)) i_drv (
        .phase   (phase),
        .sel_row (sel_row),
        .ct_row  (ct_row),
        .wl_drv  (wl_drv),
        .bl_drv  (bl_drv),
        .sl_drv  (sl_drv),
        .wr_pos  (wr_pos)
    );

    enc_wr_cellarray #(.ROWS(ROWS), .COLS(COLS)) i_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wl_drv (wl_drv),
        .bl_drv (bl_drv),
        .sl_drv (sl_drv),
        .wr_pos (wr_pos),
        .rd_row (rd_row),
        .rd_ct  (rd_ct)
    );

endmodule

// File: rtl/enc_row_writer_chk.sv
// Protocol and drive-pattern checker bound to enc_row_writer.
// Observes ports only.
module enc_row_writer_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [2*ROWS-1:0] wl_drv,
    input logic [2*COLS-1:0] bl_drv,
    input logic [2*COLS-1:0] sl_drv,
    input logic              wr_pos
);

    int full_cnt;
    int third_cnt;

    // Count wordlines at full and at one-third level.
    always_comb begin
        full_cnt  = 0;
        third_cnt = 0;
        for (int r = 0; r < ROWS; r++) begin
            if (wl_drv[2*r +: 2] == 2'd3) full_cnt++;
            if (wl_drv[2*r +: 2] == 2'd1) third_cnt++;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (wl_drv == '0 && bl_drv == '0 && sl_drv == '0 && !wr_pos)); // R1
    AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !wr_pos && full_cnt == 1)); // R2
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R2
    AST_ONE_FULL_WL: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_drv != '0) |-> (full_cnt == 1)); // R4
    AST_ERASE_COLS_GND: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_drv != '0 && !wr_pos) |-> (bl_drv == '0 && third_cnt == 0)); // R4
    AST_SET_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pos) |-> (!$past(req_ready) && !$past(wr_pos))); // R4
    AST_SET_UNSEL_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pos |-> (third_cnt == ROWS - 1 && full_cnt == 1)); // R5
    AST_LINES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        bl_drv == sl_drv); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R6
    AST_DONE_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_pos)); // R6

endmodule

bind enc_row_writer enc_row_writer_chk #(.ROWS(ROWS), .COLS(COLS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .wl_drv    (wl_drv),
    .bl_drv    (bl_drv),
    .sl_drv    (sl_drv),
    .wr_pos    (wr_pos)
);

// File: tb/test_enc_row_writer.sv
// Self-checking bench for enc_row_writer.
module test_enc_row_writer;

    localparam int ROWS    = 8;
    localparam int COLS    = 8;
    localparam int RST_CYC = 1;
    localparam int SET_CYC = 2;
    localparam int RAW     = $clog2(ROWS);
    localparam int NVEC    = 6;

    // Vector: {row, plaintext, key}
    localparam logic [RAW+2*COLS-1:0] VEC [NVEC] = '{
        {3'd2, 8'hA5, 8'h00},
        {3'd5, 8'h3C, 8'hFF},
        {3'd0, 8'hF0, 8'h55},
        {3'd7, 8'h96, 8'h96},
        {3'd3, 8'h00, 8'hFF},
        {3'd2, 8'h0F, 8'hCC}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [RAW-1:0]    req_row = '0;
    logic [COLS-1:0]   req_pt = '0;
    logic [COLS-1:0]   req_key = '0;
    logic              done;
    logic [2*ROWS-1:0] wl_drv;
    logic [2*COLS-1:0] bl_drv;
    logic [2*COLS-1:0] sl_drv;
    logic              wr_pos;
    logic [RAW-1:0]    rd_row = '0;
    logic [COLS-1:0]   rd_ct;

    int n_run  = 0;
    int n_fail = 0;
    logic [COLS-1:0] shadow [ROWS];

    always #4 clk = ~clk;

    enc_row_writer #(.ROWS(ROWS), .COLS(COLS), .RST_CYC(RST_CYC), .SET_CYC(SET_CYC)) i_enc_row_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_pt(req_pt), .req_key(req_key), .done(done),
        .wl_drv(wl_drv), .bl_drv(bl_drv), .sl_drv(sl_drv), .wr_pos(wr_pos),
        .rd_row(rd_row), .rd_ct(rd_ct)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected wordline word: code 3 on row, 1 elsewhere when setting.
    function automatic logic [2*ROWS-1:0] exp_wl(input int row, input logic setting);
        logic [2*ROWS-1:0] w;
        for (int r = 0; r < ROWS; r++)
            w[2*r +: 2] = (r == row) ? 2'd3 : (setting ? 2'd1 : 2'd0);
        return w;
    endfunction

    // Expected column word in set step: code 2 where ciphertext is 1.
    function automatic logic [2*COLS-1:0] exp_col(input logic [COLS-1:0] ct);
        logic [2*COLS-1:0] w;
        for (int c = 0; c < COLS; c++)
            w[2*c +: 2] = ct[c] ? 2'd2 : 2'd0;
        return w;
    endfunction

    task automatic check_row(input int row, input string req);
        rd_row = RAW'(row);
        #1;
        chk(rd_ct == shadow[row], req, 64'(rd_ct), 64'(shadow[row]));
    endtask

    // Issue one request; optionally hold a second request valid while busy.
    task automatic do_write(input int row, input logic [COLS-1:0] pt, input logic [COLS-1:0] key,
                            input logic hold, input int hrow);
        logic [COLS-1:0] ct;
        ct = pt ^ key;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_row   = RAW'(row);
        req_pt    = pt;
        req_key   = key;
        @(negedge clk);
        if (hold) begin
            req_row = RAW'(hrow);
            req_pt  = 8'h00;
            req_key = 8'h00;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < RST_CYC; i++) begin
            chk(req_ready == 1'b0, "R2 busy in erase", 64'(req_ready), 64'd0);
            chk(wl_drv == exp_wl(row, 1'b0) && !wr_pos, "R4 erase wordlines",
                64'({wr_pos, wl_drv}), 64'(exp_wl(row, 1'b0)));
            chk(bl_drv == '0 && sl_drv == '0, "R4 erase columns grounded",
                64'({bl_drv, sl_drv}), 64'd0);
            @(negedge clk);
        end
        for (int i = 0; i < SET_CYC; i++) begin
            chk(wl_drv == exp_wl(row, 1'b1) && wr_pos, "R5 set wordlines",
                64'({wr_pos, wl_drv}), 64'({1'b1, exp_wl(row, 1'b1)}));
            chk(bl_drv == exp_col(ct) && sl_drv == exp_col(ct), "R5 set columns",
                64'({bl_drv, sl_drv}), 64'({exp_col(ct), exp_col(ct)}));
            chk(done == 1'b0, "R6 no early done", 64'(done), 64'd0);
            @(negedge clk);
        end
        chk(done == 1'b1 && req_ready == 1'b0, "R6 done pulse", 64'({done, req_ready}), 64'b10);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R6 done single and ready back",
            64'({done, req_ready}), 64'b01);
        chk(wl_drv == '0, "R2 held request not taken", 64'(wl_drv), 64'd0);
        shadow[row] = ct;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) shadow[r] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk(req_ready == 1'b1 && done == 1'b0 && wr_pos == 1'b0, "R1 idle flags",
            64'({req_ready, done, wr_pos}), 64'b100);
        chk(wl_drv == '0 && bl_drv == '0 && sl_drv == '0, "R1 lines grounded (R9 code 0)",
            64'({wl_drv, bl_drv, sl_drv}), 64'd0);
        for (int r = 0; r < ROWS; r++) check_row(r, "R1 erased array");

        // Table of vectors: ciphertext, drive codes, other rows kept.
        for (int v = 0; v < NVEC; v++) begin
            int row;
            row = int'(VEC[v][2*COLS +: RAW]);
            do_write(row, VEC[v][COLS +: COLS], VEC[v][0 +: COLS], 1'b0, 0);
            check_row(row, (v == NVEC - 1) ? "R8 rewrite replaces row" : "R3 stored ciphertext");
            for (int r = 0; r < ROWS; r++)
                if (r != row) check_row(r, "R7 other rows unchanged");
        end

        // Request held valid during busy window must be ignored.
        do_write(1, 8'h12, 8'h00, 1'b1, 4);
        check_row(1, "R3 key zero stores plaintext");
        check_row(4, "R2 request during busy ignored");
        repeat (3) begin
            @(negedge clk);
            chk(req_ready == 1'b1 && wl_drv == '0, "R2 stays idle", 64'({req_ready, wl_drv}),
                64'({1'b1, {2*ROWS{1'b0}}}));
        end

        // Reset mid-write returns to idle and erased array.
        @(negedge clk);
        req_valid = 1'b1; req_row = 3'd6; req_pt = 8'h00; req_key = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) shadow[r] = '1;
        chk(req_ready == 1'b1 && wl_drv == '0, "R1 reset during write", 64'({req_ready, wl_drv}),
            64'({1'b1, {2*ROWS{1'b0}}}));
        check_row(6, "R1 array erased by reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule